// File: doc/BRIEF.md
# System Control Register File

This block is a bank of general-purpose 32-bit words behind a simple single-cycle register bus. It decodes a 4 KB byte window. The lower half of that window maps onto 512 stored words, indexed by the byte address divided by four. The upper half holds no storage. Any access there is refused: writes are dropped, reads return zero, and an error pulse marks the access.

Four words in the store carry board identification and status values. These values are loaded at reset, and three of those addresses return two extra status bits on every read. One address in the refused upper half acts as a control word. Writing certain values there asks the rest of the system for a reset or a power-down. The block only raises the request pulses and does not act on them.

The bus has a request strobe, a write enable, a 12-bit byte address and 32-bit write data. A read returns its data with a valid flag one cycle after the request. Only whole-word accesses exist.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to a byte address below 0x800 stores its data in word addr[11:2]. A later read of any address with the same addr[11:2] returns that data, so the two low address bits play no part. The three status words of R6 are the exception.
- R2: A write at or above byte address 0x800 changes no stored word. It does not alias into the lower half, and it pulses err high for exactly the next cycle.
- R3: A read at or above byte address 0x800 gives rvalid=1 and rdata=0 in the next cycle, with err=1 in that same cycle.
- R4: A write whose addr[11:2] equals 0x3C0 (bytes 0xF00-0xF03) with data 1 or 2 drives sys_reset_req high for exactly the next cycle.
- R5: A write to that same control word with data 3 drives sys_shutdown_req high for the next cycle. Any data other than 1, 2 or 3 raises neither request. The two requests are never high together.
- R6: Reads of word indices 0x40, 0x42 and 0x43 (bytes 0x100, 0x108, 0x10C) return the stored word ORed with 0x30000000, and the stored word itself is not modified. Word 0x41 and every other word return exactly what is stored.
- R7: After a synchronous active-high reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121 and word 0x43 holds 0x05F40121. Every other word holds zero, and all outputs are low.
- R8: rvalid is high in exactly the cycle after a read request. rdata is zero in every cycle where rvalid is low, and a write never raises rvalid.
- R9: err is high only in the cycle after an access at or above 0x800. An in-range access never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| err | output | 1 | One-cycle pulse for an out-of-range access |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The bench targets the seams between stored and refused space.

- It writes at 0x804 and then reads 0x004. A decoder that drops the top index bit would show the written data there.
- It reads the status words and word 0x41. A design that applies the OR to the whole 0x100-0x10F range, or that writes the OR back into storage, returns wrong values at 0x104 or on a second read.
- It sends the control word the data values 0, 1, 2, 3 and 4. A design that decodes only bit 0, or gates the request behind the range check, pulses the wrong request or none.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_RESET    = 2'd1,
    CMD_SHUTDOWN = 2'd2
  } sys_cmd_e;

  localparam logic [DATA_W-1:0] STATUS_SET = 32'h3000_0000;
  localparam int CTRL_WORD = 'h3C0;

  // Word index of a byte address
  function automatic int word_of(input int byte_addr);
    return byte_addr / 4;
  endfunction

  // True when the word index lies in storage
  function automatic bit stored_word(input int widx, input int nwords);
    return widx < nwords;
  endfunction

  // Words that return extra status bits on a read
  function automatic bit status_word(input int widx);
    return (widx == 'h40) || (widx == 'h42) || (widx == 'h43);
  endfunction

  // Reset contents of a storage word
  function automatic logic [DATA_W-1:0] preset_of(input int widx);
    case (widx)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  // Decode of data written to the control word
  function automatic sys_cmd_e cmd_of(input logic [DATA_W-1:0] d);
    if (d == 32'd1 || d == 32'd2) return CMD_RESET;
    if (d == 32'd3)               return CMD_SHUTDOWN;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NWORDS = 512,
  localparam int SW = $clog2(NWORDS)
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [SW-1:0]     widx,
  output logic              wr_ok,
  output logic              rd_en,
  output logic              rd_ok,
  output logic              oor,
  output logic              ctrl_wr,
  output logic              stat_hit
);
  localparam int FW = ADDR_W - 2;

  logic [FW-1:0] full_idx;
  logic          in_rng;

  assign full_idx = addr[ADDR_W-1:2];
  assign widx     = full_idx[SW-1:0];

  always_comb begin
    in_rng   = stored_word(int'(full_idx), NWORDS);
    stat_hit = status_word(int'(full_idx));
    wr_ok    = req && we && in_rng;
    rd_en    = req && !we;
    rd_ok    = rd_en && in_rng;
    oor      = req && !in_rng;
    ctrl_wr  = req && we && (int'(full_idx) == CTRL_WORD);
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int NWORDS = 512,
  localparam int SW = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= preset_of(i);
    end else if (wr_en) begin
      mem[idx] <= wdata;
    end
  end

  assign rword = mem[idx];

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sys_reset_req,
  output logic              sys_shutdown_req
);
  sys_cmd_e cmd;

  assign cmd = ctrl_wr ? cmd_of(wdata) : CMD_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_reset_req    <= 1'b0;
      sys_shutdown_req <= 1'b0;
    end else begin
      sys_reset_req    <= (cmd == CMD_RESET);
      sys_shutdown_req <= (cmd == CMD_SHUTDOWN);
    end
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NWORDS = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              err,
  output logic              sys_reset_req,
  output logic              sys_shutdown_req
);
  localparam int SW = $clog2(NWORDS);

  // Named internal events, also observed by the checker
  logic [SW-1:0]     acc_idx;
  logic              acc_wr_ok;
  logic              acc_rd;
  logic              acc_rd_ok;
  logic              acc_oor;
  logic              acc_ctrl;
  logic              acc_stat;
  logic [DATA_W-1:0] store_word;
  logic [DATA_W-1:0] rd_next;

  sysctl_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
    .req      (req),
    .we       (we),
    .addr     (addr),
    .widx     (acc_idx),
    .wr_ok    (acc_wr_ok),
    .rd_en    (acc_rd),
    .rd_ok    (acc_rd_ok),
    .oor      (acc_oor),
    .ctrl_wr  (acc_ctrl),
    .stat_hit (acc_stat)
  );

  sysctl_store #(.NWORDS(NWORDS)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (acc_wr_ok),
    .idx   (acc_idx),
    .wdata (wdata),
    .rword (store_word)
  );

  sysctl_ctrl u_ctrl (
    .clk              (clk),
    .rst              (rst),
    .ctrl_wr          (acc_ctrl),
    .wdata            (wdata),
    .sys_reset_req    (sys_reset_req),
    .sys_shutdown_req (sys_shutdown_req)
  );

  always_comb begin
    rd_next = '0;
    if (acc_rd_ok) rd_next = store_word | (acc_stat ? STATUS_SET : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rdata  <= rd_next;
      rvalid <= acc_rd;
      err    <= acc_oor;
    end
  end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int ADDR_W = 12,
  parameter int NWORDS = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              rvalid,
  input logic              err,
  input logic              sys_reset_req,
  input logic              sys_shutdown_req,
  input logic              acc_oor
);
  localparam int LIMIT = NWORDS * 4;
  localparam int CTRL  = 'h3C0;

  logic far_addr;
  logic ctrl_w;

  assign far_addr = int'(addr) >= LIMIT;
  assign ctrl_w   = req && we && (int'(addr[ADDR_W-1:2]) == CTRL);

  a_r8_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    req && !we |=> rvalid);

  a_r8_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> !rvalid && rdata == '0);

  a_r3_far_read_zero: assert property (@(posedge clk) disable iff (rst)
    req && !we && far_addr |=> rdata == '0 && err);

  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req && far_addr));

  a_r2_decode_oor: assert property (@(posedge clk) disable iff (rst)
    acc_oor == (req && far_addr));

  a_r4_reset_cause: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(ctrl_w && (wdata == 32'd1 || wdata == 32'd2)));

  a_r5_shutdown_cause: assert property (@(posedge clk) disable iff (rst)
    sys_shutdown_req |-> $past(ctrl_w && wdata == 32'd3));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sys_reset_req, sys_shutdown_req}));

  a_r2_ctrl_flagged: assert property (@(posedge clk) disable iff (rst)
    ctrl_w |=> err);

endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .req              (req),
  .we               (we),
  .addr             (addr),
  .wdata            (wdata),
  .rdata            (rdata),
  .rvalid           (rvalid),
  .err              (err),
  .sys_reset_req    (sys_reset_req),
  .sys_shutdown_req (sys_shutdown_req),
  .acc_oor          (acc_oor)
);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, err, sys_reset_req, sys_shutdown_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Expected outputs, one entry per cycle: flags are {rvalid, err, reset, shutdown}
  logic [31:0] q_rd [$];
  logic [3:0]  q_fl [$];
  string       q_tag [$];

  always #4 clk = ~clk;

  sysctl_regfile u_sysctl_regfile (
    .clk (clk), .rst (rst), .req (req), .we (we), .addr (addr), .wdata (wdata),
    .rdata (rdata), .rvalid (rvalid), .err (err),
    .sys_reset_req (sys_reset_req), .sys_shutdown_req (sys_shutdown_req)
  );

  // Monitor: compares after each rising edge
  always @(posedge clk) begin
    #2;
    if (q_rd.size() > 0) begin
      logic [31:0] erd;
      logic [3:0]  efl;
      string       t;
      erd = q_rd.pop_front();
      efl = q_fl.pop_front();
      t   = q_tag.pop_front();
      checks++;
      if (rdata !== erd || {rvalid, err, sys_reset_req, sys_shutdown_req} !== efl) begin
        fails++;
        $display("FAIL %s: rdata=%h flags=%b expected rdata=%h flags=%b",
                 t, rdata, {rvalid, err, sys_reset_req, sys_shutdown_req}, erd, efl);
      end
    end
  end

  function automatic bit far(input logic [11:0] a);
    return a >= 12'h800;
  endfunction

  // Driver: one cycle per call, pushes what the next cycle must show
  task automatic cyc(input bit r, input bit w, input logic [11:0] a,
                     input logic [31:0] d, input logic [31:0] exp_rd,
                     input logic [1:0] exp_req, input string t);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    q_rd.push_back((r && !w) ? exp_rd : 32'h0);
    q_fl.push_back({r && !w, r && far(a), exp_req});
    q_tag.push_back(t);
  endtask

  task automatic idle(input string t);
    cyc(0, 0, '0, '0, '0, 2'b00, t);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    cyc(1, 0, a, '0, e, 2'b00, t);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] rq,
                    input string t);
    cyc(1, 1, a, d, '0, rq, t);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R7 outputs low after reset");
    // R7 presets, R6 status bits
    rd(12'h100, 32'h35F2_0121, "R7/R6 word 0x40");
    rd(12'h104, 32'h0000_0002, "R7 word 0x41 no OR");
    rd(12'h108, 32'h35F3_0121, "R7/R6 word 0x42");
    rd(12'h10C, 32'h35F4_0121, "R7/R6 word 0x43");
    rd(12'h000, 32'h0, "R7 word 0 zero");
    rd(12'h7FC, 32'h0, "R7 top word zero");
    // R1 store and read back, low bits ignored
    wr(12'h010, 32'hA5A5_1234, 2'b00, "R8 write gives no rvalid");
    rd(12'h010, 32'hA5A5_1234, "R1 readback");
    rd(12'h013, 32'hA5A5_1234, "R1 low bits ignored");
    wr(12'h7FE, 32'hDEAD_BEEF, 2'b00, "R1 top word write");
    idle("R8 idle after write");
    rd(12'h7FC, 32'hDEAD_BEEF, "R1 top word readback");
    // R2 far write discarded, no alias
    wr(12'h804, 32'h1111_2222, 2'b00, "R2 far write flagged");
    rd(12'h004, 32'h0, "R2 no alias into low half");
    rd(12'h804, 32'h0, "R3 far read zero");
    rd(12'hFFC, 32'h0, "R3 last address");
    // R4/R5 control word
    wr(12'hF00, 32'd1, 2'b10, "R4 data 1 reset");
    idle("R4 pulse single cycle");
    wr(12'hF00, 32'd2, 2'b10, "R4 data 2 reset");
    wr(12'hF00, 32'd3, 2'b01, "R5 data 3 shutdown");
    wr(12'hF00, 32'd0, 2'b00, "R5 data 0 none");
    wr(12'hF02, 32'd4, 2'b00, "R5 data 4 none");
    wr(12'hF04, 32'd1, 2'b00, "R5 neighbour word none");
    rd(12'hF00, 32'h0, "R3 control word reads zero");
    // R6 OR on read only
    wr(12'h100, 32'h0000_0005, 2'b00, "R9 in-range write no err");
    rd(12'h100, 32'h3000_0005, "R6 OR applied");
    rd(12'h100, 32'h3000_0005, "R6 stored word unchanged");
    wr(12'h104, 32'h0000_0005, 2'b00, "R6 word 0x41 write");
    rd(12'h104, 32'h0000_0005, "R6 word 0x41 plain");
    wr(12'h10C, 32'h0, 2'b00, "R6 word 0x43 clear");
    rd(12'h10C, 32'h3000_0000, "R6 cleared word still ORed");
    rd(12'h10E, 32'h3000_0000, "R6 low bits ignored on status");
    idle("R8 rvalid drops");
    idle("R9 err stays low");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule